// File: doc/BRIEF.md
# Phase Detector with Lock Detect

This block compares a reference pulse train with a divided feedback pulse train and turns the timing difference between them into charge-pump requests. It has two request outputs, one that pushes the loop filter high and one that pulls it low. When neither output is asserted, the pump is meant to float in high impedance. A polarity input swaps the two drive directions, so one detector serves a VCO whose frequency rises with control voltage as well as one whose frequency falls with it. Both pulse inputs are assumed to be synchronous to the system clock. A rising edge is detected on the first clock edge at which an input is seen high after being low.

The detector core is a two-flop phase-frequency detector written as a state machine. Its states are `PD_IDLE`, `PD_REF_AHEAD`, `PD_FB_AHEAD` and `PD_CLEAR`.
- `PD_IDLE` moves to `PD_REF_AHEAD` on a lone reference edge and to `PD_FB_AHEAD` on a lone feedback edge. It moves straight to `PD_CLEAR` when both edges arrive on the same clock.
- `PD_REF_AHEAD` moves to `PD_CLEAR` on the first feedback edge. `PD_FB_AHEAD` moves to `PD_CLEAR` on the first reference edge.
- `PD_CLEAR` asserts both outputs for `MIN_PULSE` cycles to avoid a dead band, then returns to `PD_IDLE`.

Every move into `PD_CLEAR` ends one comparison. The number of clock cycles spent ahead becomes the error width for that comparison.

A lock filter with states `LK_UNLOCKED` and `LK_LOCKED` grades each error width against a programmable window. Any comparison whose error is at least the window forces `LK_UNLOCKED` and clears the run counter. Each comparison whose error is below the window adds one to the run. The move `LK_UNLOCKED` to `LK_LOCKED` happens when the run reaches `LOCK_COUNT`, which defaults to 3.

Top module: `pfd_lock_top`

## Requirements
- R1: While reset is asserted and right after it, `pump_hi`, `pump_lo` and `lock_flag` are 0, and the consecutive-match count is zero.
- R2: With `pol_sel`=1, a reference edge arriving first asserts `pump_hi` (and not `pump_lo`) from the clock after that edge until the feedback edge.
- R3: With `pol_sel`=1, a feedback edge arriving first asserts `pump_lo` (and not `pump_hi`) until the reference edge.
- R4: With `pol_sel`=0, the two directions are swapped: reference first asserts `pump_lo`, feedback first asserts `pump_hi`.
- R5: When the lagging edge arrives, both outputs are asserted together for exactly `MIN_PULSE` cycles (default 2), then both return to 0.
- R6: While one side is ahead, further edges on the leading input are ignored. The error width is measured from the first leading edge.
- R7: The error width is the number of clock edges from the leading edge to the lagging edge (0 when both arrive together). A comparison with error at least `win_cycles` clears `lock_flag` on the clock of the lagging edge.
- R8: `lock_flag` rises on the clock of the lagging edge of the `LOCK_COUNT`-th consecutive comparison (default 3) whose error is below `win_cycles`. Any large error restarts that count.
- R9: Edges arriving while both outputs are in the clear pulse are ignored and start no new comparison.
- R10: Reference and feedback edges on the same clock give only the clear pulse and count as a zero-error comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Reference divider pulse, synchronous to clk |
| fb_pulse | input | 1 | Feedback divider pulse, synchronous to clk |
| pol_sel | input | 1 | 1: reference ahead drives high; 0: swapped |
| win_cycles | input | ERR_W | Lock window width in clock cycles |
| pump_hi | output | 1 | Request to source current into the loop filter |
| pump_lo | output | 1 | Request to sink current from the loop filter |
| lock_flag | output | 1 | Lock indication with hysteresis |

## Verification
The detector is driven with the reference leading, the feedback leading, and both edges arriving together. Each case is run under both polarities, which separates a swapped direction from a stuck one. Error widths of 7, 8 and 10 cycles against a window of 8 probe the exact strict/non-strict boundary of the lock window. A run of small errors interrupted by a large one shows that the count restarts rather than resuming. A repeated leading edge shows whether the error is measured from the first leading edge or from the latest. An edge placed inside the clear pulse shows whether a stray comparison would start.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PD_IDLE      = 2'd0,
        PD_REF_AHEAD = 2'd1,
        PD_FB_AHEAD  = 2'd2,
        PD_CLEAR     = 2'd3
    } pd_state_e;

    typedef enum logic {
        LK_UNLOCKED = 1'b0,
        LK_LOCKED   = 1'b1
    } lk_state_e;

    localparam int NUM_INPUTS = 2;
    localparam int IDX_REF    = 0;
    localparam int IDX_FB     = 1;

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] din_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                din_q[g] <= 1'b0;
            end else begin
                din_q[g] <= din[g];
            end
        end
        assign rise[g] = din[g] & ~din_q[g];
    end

endmodule

// File: rtl/pfd_core_fsm.sv
module pfd_core_fsm
    import pfd_pkg::*;
#(
    parameter int ERR_W     = 8,
    parameter int MIN_PULSE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             fb_rise,
    output pd_state_e        state_o,
    output logic             cmp_done,
    output logic [ERR_W-1:0] cmp_err
);

    localparam int CLR_W = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
    localparam logic [ERR_W-1:0] ERR_MAX  = {ERR_W{1'b1}};
    localparam logic [CLR_W-1:0] CLR_LOAD = CLR_W'(MIN_PULSE - 1);

    pd_state_e        state_q, state_d;
    logic [ERR_W-1:0] err_q;
    logic [CLR_W-1:0] clr_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: begin
                if (ref_rise && fb_rise) begin
                    state_d = PD_CLEAR;
                end else if (ref_rise) begin
                    state_d = PD_REF_AHEAD;
                end else if (fb_rise) begin
                    state_d = PD_FB_AHEAD;
                end
            end
            PD_REF_AHEAD: if (fb_rise)  state_d = PD_CLEAR;
            PD_FB_AHEAD:  if (ref_rise) state_d = PD_CLEAR;
            PD_CLEAR:     if (clr_q == '0) state_d = PD_IDLE;
            default:      state_d = PD_IDLE;
        endcase
    end

    // state register and datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PD_IDLE;
            err_q   <= '0;
            clr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PD_IDLE) begin
                err_q <= ERR_W'(1);
            end else if ((state_q == PD_REF_AHEAD || state_q == PD_FB_AHEAD)
                         && state_d != PD_CLEAR && err_q != ERR_MAX) begin
                err_q <= err_q + 1'b1;
            end
            if (state_d == PD_CLEAR && state_q != PD_CLEAR) begin
                clr_q <= CLR_LOAD;
            end else if (state_q == PD_CLEAR && clr_q != '0) begin
                clr_q <= clr_q - 1'b1;
            end
        end
    end

    // comparison result outputs
    always_comb begin
        cmp_done = 1'b0;
        cmp_err  = '0;
        unique case (state_q)
            PD_IDLE: begin
                cmp_done = ref_rise && fb_rise;
            end
            PD_REF_AHEAD: begin
                cmp_done = fb_rise;
                cmp_err  = err_q;
            end
            PD_FB_AHEAD: begin
                cmp_done = ref_rise;
                cmp_err  = err_q;
            end
            PD_CLEAR: begin
                cmp_done = 1'b0;
            end
            default: begin
                cmp_done = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pfd_pump_map.sv
module pfd_pump_map
    import pfd_pkg::*;
(
    input  pd_state_e state_i,
    input  logic      pol_sel,
    output logic      pump_hi,
    output logic      pump_lo
);

    logic lead_up, lead_dn;

    always_comb begin
        lead_up = 1'b0;
        lead_dn = 1'b0;
        unique case (state_i)
            PD_IDLE:      begin lead_up = 1'b0; lead_dn = 1'b0; end
            PD_REF_AHEAD: begin lead_up = 1'b1; lead_dn = 1'b0; end
            PD_FB_AHEAD:  begin lead_up = 1'b0; lead_dn = 1'b1; end
            PD_CLEAR:     begin lead_up = 1'b1; lead_dn = 1'b1; end
            default:      begin lead_up = 1'b0; lead_dn = 1'b0; end
        endcase
        pump_hi = pol_sel ? lead_up : lead_dn;
        pump_lo = pol_sel ? lead_dn : lead_up;
    end

endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter
    import pfd_pkg::*;
#(
    parameter int ERR_W      = 8,
    parameter int LOCK_COUNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_done,
    input  logic [ERR_W-1:0] cmp_err,
    input  logic [ERR_W-1:0] win_cycles,
    output logic             lock_flag
);

    localparam int RUN_W = (LOCK_COUNT > 1) ? $clog2(LOCK_COUNT) : 1;
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_COUNT - 1);

    lk_state_e        state_q, state_d;
    logic [RUN_W-1:0] run_q,   run_d;
    logic             err_big;

    assign err_big = (cmp_err >= win_cycles);

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            LK_UNLOCKED: begin
                if (cmp_done) begin
                    if (err_big) begin
                        run_d = '0;
                    end else if (run_q >= RUN_TOP) begin
                        state_d = LK_LOCKED;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
            end
            LK_LOCKED: begin
                if (cmp_done && err_big) begin
                    state_d = LK_UNLOCKED;
                    run_d   = '0;
                end
            end
            default: begin
                state_d = LK_UNLOCKED;
                run_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_UNLOCKED;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LK_LOCKED:   lock_flag = 1'b1;
            LK_UNLOCKED: lock_flag = 1'b0;
            default:     lock_flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int ERR_W      = 8,
    parameter int MIN_PULSE  = 2,
    parameter int LOCK_COUNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    input  logic             pol_sel,
    input  logic [ERR_W-1:0] win_cycles,
    output logic             pump_hi,
    output logic             pump_lo,
    output logic             lock_flag
);

    logic [NUM_INPUTS-1:0] pulses, rises;
    pd_state_e             pd_state;
    logic                  cmp_done;
    logic [ERR_W-1:0]      cmp_err;

    assign pulses[IDX_REF] = ref_pulse;
    assign pulses[IDX_FB]  = fb_pulse;

    pfd_edge_det #(.WIDTH(NUM_INPUTS)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pulses),
        .rise  (rises)
    );

    pfd_core_fsm #(.ERR_W(ERR_W), .MIN_PULSE(MIN_PULSE)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (rises[IDX_REF]),
        .fb_rise  (rises[IDX_FB]),
        .state_o  (pd_state),
        .cmp_done (cmp_done),
        .cmp_err  (cmp_err)
    );

    pfd_pump_map u_map (
        .state_i (pd_state),
        .pol_sel (pol_sel),
        .pump_hi (pump_hi),
        .pump_lo (pump_lo)
    );

    pfd_lock_filter #(.ERR_W(ERR_W), .LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_done   (cmp_done),
        .cmp_err    (cmp_err),
        .win_cycles (win_cycles),
        .lock_flag  (lock_flag)
    );

endmodule

// File: rtl/pfd_lock_checker.sv
module pfd_lock_checker #(
    parameter int MIN_PULSE = 2
) (
    input logic clk,
    input logic rst_n,
    input logic pump_hi,
    input logic pump_lo,
    input logic lock_flag
);

    logic       both_on;
    logic       both_prev;
    logic [7:0] both_run;

    assign both_on = pump_hi && pump_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            both_run  <= '0;
            both_prev <= 1'b0;
        end else begin
            both_prev <= both_on;
            if (!both_on) begin
                both_run <= '0;
            end else if (both_run != 8'hFF) begin
                both_run <= both_run + 1'b1;
            end
        end
    end

    // R1: reset leaves every output idle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!pump_hi && !pump_lo && !lock_flag));

    // R7: lock only drops at the end of a comparison
    assert_drop_on_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_flag) |-> both_on);

    // R8: lock only rises at the end of a comparison
    assert_rise_on_compare_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> both_on);

    // R5: clear pulse never exceeds its width
    assert_clear_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        both_on |-> (both_run < 8'(MIN_PULSE)));

    // R5: clear pulse never ends early
    assert_clear_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (both_prev && !both_on) |-> (both_run == 8'(MIN_PULSE)));

endmodule

bind pfd_lock_top pfd_lock_checker #(.MIN_PULSE(MIN_PULSE)) u_pfd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pump_hi   (pump_hi),
    .pump_lo   (pump_lo),
    .lock_flag (lock_flag)
);

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;

    localparam int CLK_PERIOD = 10;
    localparam int ERR_W      = 8;
    localparam int MINP       = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_pulse = 1'b0;
    logic             fb_pulse = 1'b0;
    logic             pol_sel = 1'b1;
    logic [ERR_W-1:0] win_cycles = 8'd8;
    logic             pump_hi, pump_lo, lock_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    pfd_lock_top #(.ERR_W(ERR_W), .MIN_PULSE(MINP), .LOCK_COUNT(3)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_pulse  (ref_pulse),
        .fb_pulse   (fb_pulse),
        .pol_sel    (pol_sel),
        .win_cycles (win_cycles),
        .pump_hi    (pump_hi),
        .pump_lo    (pump_lo),
        .lock_flag  (lock_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // one comparison: lead input first, lag input d cycles later
    task automatic do_compare(input bit ref_first, input int d, input logic exp_lock,
                              input string tag);
        logic exp_hi;
        exp_hi = (ref_first == pol_sel);
        tick();
        if (ref_first) ref_pulse = 1'b1; else fb_pulse = 1'b1;
        tick();
        ref_pulse = 1'b0; fb_pulse = 1'b0;
        check_bit({tag, " lead pump_hi"}, pump_hi, exp_hi);
        check_bit({tag, " lead pump_lo"}, pump_lo, ~exp_hi);
        repeat (d - 1) tick();
        if (ref_first) fb_pulse = 1'b1; else ref_pulse = 1'b1;
        tick();
        ref_pulse = 1'b0; fb_pulse = 1'b0;
        check_bit({tag, " R5 clear hi c1"}, pump_hi, 1'b1);
        check_bit({tag, " R5 clear lo c1"}, pump_lo, 1'b1);
        check_bit({tag, " lock"}, lock_flag, exp_lock);
        tick();
        check_bit({tag, " R5 clear both c2"}, pump_hi & pump_lo, 1'b1);
        tick();
        check_bit({tag, " R5 idle hi"}, pump_hi, 1'b0);
        check_bit({tag, " R5 idle lo"}, pump_lo, 1'b0);
    endtask

    task automatic test_reset();
        check_bit("R1 pump_hi", pump_hi, 1'b0);
        check_bit("R1 pump_lo", pump_lo, 1'b0);
        check_bit("R1 lock_flag", lock_flag, 1'b0);
    endtask

    task automatic test_simultaneous(input logic exp_lock);
        tick();
        ref_pulse = 1'b1; fb_pulse = 1'b1;
        tick();
        ref_pulse = 1'b0; fb_pulse = 1'b0;
        check_bit("R10 both c1", pump_hi & pump_lo, 1'b1);
        check_bit("R8 lock after third small", lock_flag, exp_lock);
        tick();
        check_bit("R10 both c2", pump_hi & pump_lo, 1'b1);
        tick();
        check_bit("R10 idle", pump_hi | pump_lo, 1'b0);
    endtask

    task automatic test_repeat_lead();
        // lock is high here; second ref edge must not restart measurement
        tick(); ref_pulse = 1'b1;
        tick(); ref_pulse = 1'b0;
        check_bit("R6 ahead hi", pump_hi, 1'b1);
        tick(); tick();
        ref_pulse = 1'b1;
        tick(); ref_pulse = 1'b0;
        check_bit("R6 still ahead hi", pump_hi, 1'b1);
        check_bit("R6 still ahead lo", pump_lo, 1'b0);
        repeat (5) tick();
        fb_pulse = 1'b1;
        tick(); fb_pulse = 1'b0;
        check_bit("R6 error from first edge drops lock", lock_flag, 1'b0);
        tick(); tick();
    endtask

    task automatic test_edge_in_clear();
        tick(); ref_pulse = 1'b1;
        tick(); ref_pulse = 1'b0;
        tick(); fb_pulse = 1'b1;
        tick(); fb_pulse = 1'b0; ref_pulse = 1'b1;
        check_bit("R9 clear c1", pump_hi & pump_lo, 1'b1);
        tick(); ref_pulse = 1'b0;
        check_bit("R9 clear c2", pump_hi & pump_lo, 1'b1);
        tick();
        check_bit("R9 ignored hi", pump_hi, 1'b0);
        check_bit("R9 ignored lo", pump_lo, 1'b0);
        tick();
        check_bit("R9 still idle", pump_hi | pump_lo, 1'b0);
    endtask

    initial begin
        repeat (3) tick();
        test_reset();
        rst_n = 1'b1;
        tick();
        test_reset();
        // R2: reference leads, polarity 1
        do_compare(1'b1, 3, 1'b0, "R2");
        // R3: feedback leads, polarity 1
        do_compare(1'b0, 4, 1'b0, "R3");
        // R8 / R10: third small comparison locks
        test_simultaneous(1'b1);
        // R7: large error drops lock
        do_compare(1'b1, 10, 1'b0, "R7 large");
        // R7 boundary: error equal to window is large
        do_compare(1'b1, 6, 1'b0, "R8 small");
        do_compare(1'b1, 8, 1'b0, "R7 equal window");
        do_compare(1'b0, 7, 1'b0, "R8 restart 1");
        do_compare(1'b1, 7, 1'b0, "R8 restart 2");
        do_compare(1'b0, 7, 1'b1, "R8 restart 3");
        // R4: polarity swap
        pol_sel = 1'b0;
        do_compare(1'b1, 2, 1'b1, "R4 ref lead");
        do_compare(1'b0, 2, 1'b1, "R4 fb lead");
        pol_sel = 1'b1;
        test_repeat_lead();
        test_edge_in_clear();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule